// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a data cache that sits between a processor load/store port carrying 32-bit words and a memory port that moves whole 128-bit lines. The cache has one frame for each index value, and each frame holds a line of four words. An address maps to the frame given by its line address modulo the frame count. Each frame keeps a tag, a valid flag and a modified (dirty) flag. A lookup reads the tag and the line in the same cycle. On a hit, a 4-way word selector returns one word of the line.

Stores change only the cached copy. They use per-byte enables and mark the line as modified. Memory is written only when a modified line is evicted. A store that misses first loads the line and then completes as a hit. On any miss the processor port stalls. If the victim line is modified, the cache first writes it back as a full line and then issues the fill. If the victim is clean, only the fill is issued. The processor must hold its request steady while it is stalled.

Top module: `dm_wb_cache`

## Requirements
- R1: An address splits as follows. The byte offset is bits 1:0 and is ignored on reads. The word select is bits 3:2, the index is bits 3+INDEX_W:4 and the tag is the bits above the index. With the default INDEX_W=12 this gives a 16-bit tag in bits 31:16 and a 12-bit index in bits 15:4.
- R2: After reset every frame is invalid, so the first access to any address misses. No memory request is pending while the processor is idle.
- R3: A read hit raises `cpu_req_ready` in the same cycle as the request. In that cycle `cpu_rdata` carries word k of the line, which is line bits 32k+31:32k, where k is the word select.
- R4: A hit requires the frame to be valid and its stored tag to equal the address tag. An access to the same index with a different tag misses.
- R5: A write hit is accepted in one cycle. It changes byte b of the selected word (bits 8b+7:8b) only where `cpu_req_be[b]` is 1. It marks the line modified, even when all enables are 0. It makes no memory request. Write addresses are word-aligned.
- R6: A write miss loads the line from memory and then applies the write as a hit. Later reads return the loaded data merged with the written bytes.
- R7: A miss whose victim is invalid or clean makes exactly one memory transfer: a read of the requested line at the line-aligned address. A filled line starts clean.
- R8: A miss whose victim is modified first issues a write (`mem_req_write`=1) of the whole victim line at the victim's line address. A read of the requested line follows.
- R9: `cpu_req_ready` stays low from the cycle a miss is detected until the fill response has been taken. In the cycle after the response, the held request hits.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request's write flag, address and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor access request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_req_be | input | 4 | Store byte enables |
| cpu_req_ready | output | 1 | Access completes this cycle (hit) |
| cpu_rdata | output | 32 | Load data, valid with ready on a read |
| mem_req_valid | output | 1 | Line transfer request |
| mem_req_write | output | 1 | 1 = write-back, 0 = fill read |
| mem_req_addr | output | 32 | Line-aligned memory address |
| mem_req_wdata | output | 128 | Line written back |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_resp_valid | input | 1 | Fill data present |
| mem_resp_rdata | input | 128 | Fill line |

## Verification
The hardest case to reach from the ports is an eviction of a modified line whose contents later come back from memory. To reach it, the stimulus must store into a line, force a conflicting tag onto the same index, and then read the first line again. Only that round trip shows whether the write-back carried the right address and the right merged bytes. The bench uses a four-frame configuration and cycles three tags through every index, with a store on each visit, so every index sees repeated dirty evictions. It keeps a byte-accurate image of memory to check each written-back line and each later reload. Every memory request is also held unacknowledged for one cycle to show that it stays stable.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int ADDR_W      = 32;
    localparam int WORD_W      = 32;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int LINE_WORDS  = 4;
    localparam int LINE_W      = WORD_W * LINE_WORDS;
    localparam int BOFF_W      = $clog2(WORD_BYTES);
    localparam int WSEL_W      = $clog2(LINE_WORDS);
    localparam int LINE_OFF_W  = BOFF_W + WSEL_W;

    typedef logic [WORD_W-1:0]     word_t;
    typedef logic [LINE_W-1:0]     line_t;
    typedef logic [WORD_BYTES-1:0] be_t;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_EVICT,
        MS_FETCH,
        MS_AWAIT
    } miss_st_e;

    function automatic word_t merge_bytes(word_t old_w, word_t new_w, be_t be);
        word_t r;
        r = old_w;
        for (int b = 0; b < WORD_BYTES; b++)
            if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store
    import dmc_pkg::*;
#(
    parameter int INDEX_W = 12,
    parameter int TAG_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INDEX_W-1:0] rd_idx,
    output logic               rd_valid,
    output logic               rd_dirty,
    output logic [TAG_W-1:0]   rd_tag,
    input  logic               fill_en,
    input  logic [INDEX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic               mark_en,
    input  logic [INDEX_W-1:0] mark_idx
);
    localparam int FRAMES = 1 << INDEX_W;

    logic [FRAMES-1:0] valid_q;
    logic [FRAMES-1:0] dirty_q;
    logic [TAG_W-1:0]  tag_q [FRAMES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[fill_idx] <= 1'b1;
                dirty_q[fill_idx] <= 1'b0;
            end
            if (mark_en) dirty_q[mark_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_idx] <= fill_tag;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    AST_FILL_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]); // R7

    AST_MARK_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
        mark_en |-> valid_q[mark_idx]); // R5
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
    import dmc_pkg::*;
#(
    parameter int INDEX_W = 12
) (
    input  logic               clk,
    input  logic [INDEX_W-1:0] rd_idx,
    output line_t              rd_line,
    input  logic               fill_en,
    input  logic [INDEX_W-1:0] fill_idx,
    input  line_t              fill_line,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [WSEL_W-1:0]  wr_wsel,
    input  word_t              wr_data,
    input  be_t                wr_be
);
    localparam int FRAMES = 1 << INDEX_W;

    line_t lines_q [FRAMES];

    always_ff @(posedge clk) begin
        if (fill_en)
            lines_q[fill_idx] <= fill_line;
        else if (wr_en)
            lines_q[wr_idx][wr_wsel*WORD_W +: WORD_W] <=
                merge_bytes(lines_q[wr_idx][wr_wsel*WORD_W +: WORD_W], wr_data, wr_be);
    end

    assign rd_line = lines_q[rd_idx];
endmodule

// File: rtl/dmc_word_mux.sv
module dmc_word_mux
    import dmc_pkg::*;
(
    input  line_t             line_in,
    input  logic [WSEL_W-1:0] sel,
    output word_t             word_out
);
    word_t lane [LINE_WORDS];

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_lane
        assign lane[w] = (sel == WSEL_W'(w)) ? line_in[w*WORD_W +: WORD_W] : '0;
    end

    always_comb begin
        word_out = '0;
        for (int w = 0; w < LINE_WORDS; w++) word_out = word_out | lane[w];
    end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
    import dmc_pkg::*;
#(
    parameter int INDEX_W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cpu_req_valid,
    input  logic         cpu_req_write,
    input  logic [31:0]  cpu_req_addr,
    input  logic [31:0]  cpu_req_wdata,
    input  logic [3:0]   cpu_req_be,
    output logic         cpu_req_ready,
    output logic [31:0]  cpu_rdata,
    output logic         mem_req_valid,
    output logic         mem_req_write,
    output logic [31:0]  mem_req_addr,
    output logic [127:0] mem_req_wdata,
    input  logic         mem_req_ready,
    input  logic         mem_resp_valid,
    input  logic [127:0] mem_resp_rdata
);
    localparam int TAG_W = ADDR_W - INDEX_W - LINE_OFF_W;

    logic [TAG_W-1:0]   req_tag;
    logic [INDEX_W-1:0] req_idx;
    logic [WSEL_W-1:0]  req_wsel;

    assign req_tag  = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = cpu_req_addr[LINE_OFF_W +: INDEX_W];
    assign req_wsel = cpu_req_addr[BOFF_W +: WSEL_W];

    miss_st_e           state_q;
    logic [INDEX_W-1:0] miss_idx_q;
    logic [TAG_W-1:0]   miss_tag_q;
    logic [TAG_W-1:0]   victim_tag_q;

    logic [INDEX_W-1:0] lk_idx;
    logic               lk_valid, lk_dirty, hit, fill_en, wr_en;
    logic [TAG_W-1:0]   lk_tag;
    line_t              lk_line;

    assign lk_idx  = (state_q == MS_IDLE) ? req_idx : miss_idx_q;
    assign hit     = lk_valid && (lk_tag == req_tag);
    assign cpu_req_ready = (state_q == MS_IDLE) && hit;
    assign wr_en   = cpu_req_valid && cpu_req_ready && cpu_req_write;
    assign fill_en = (state_q == MS_AWAIT) && mem_resp_valid;

    dmc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_valid (lk_valid),
        .rd_dirty (lk_dirty),
        .rd_tag   (lk_tag),
        .fill_en  (fill_en),
        .fill_idx (miss_idx_q),
        .fill_tag (miss_tag_q),
        .mark_en  (wr_en),
        .mark_idx (req_idx)
    );

    dmc_data_store #(.INDEX_W(INDEX_W)) u_data (
        .clk       (clk),
        .rd_idx    (lk_idx),
        .rd_line   (lk_line),
        .fill_en   (fill_en),
        .fill_idx  (miss_idx_q),
        .fill_line (mem_resp_rdata),
        .wr_en     (wr_en),
        .wr_idx    (req_idx),
        .wr_wsel   (req_wsel),
        .wr_data   (cpu_req_wdata),
        .wr_be     (cpu_req_be)
    );

    dmc_word_mux u_mux (
        .line_in  (lk_line),
        .sel      (req_wsel),
        .word_out (cpu_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= MS_IDLE;
            miss_idx_q   <= '0;
            miss_tag_q   <= '0;
            victim_tag_q <= '0;
        end else begin
            unique case (state_q)
                MS_IDLE: if (cpu_req_valid && !hit) begin
                    miss_idx_q   <= req_idx;
                    miss_tag_q   <= req_tag;
                    victim_tag_q <= lk_tag;
                    state_q      <= (lk_valid && lk_dirty) ? MS_EVICT : MS_FETCH;
                end
                MS_EVICT: if (mem_req_ready) state_q <= MS_FETCH;
                MS_FETCH: if (mem_req_ready) state_q <= MS_AWAIT;
                MS_AWAIT: if (mem_resp_valid) state_q <= MS_IDLE;
                default:  state_q <= MS_IDLE;
            endcase
        end
    end

    assign mem_req_valid = (state_q == MS_EVICT) || (state_q == MS_FETCH);
    assign mem_req_write = (state_q == MS_EVICT);
    assign mem_req_addr  = {(state_q == MS_EVICT) ? victim_tag_q : miss_tag_q,
                            miss_idx_q, {LINE_OFF_W{1'b0}}};
    assign mem_req_wdata = lk_line;

    AST_MISS_STARTS_REFILL: assert property (@(posedge clk) disable iff (rst)
        (state_q == MS_IDLE && cpu_req_valid && !cpu_req_ready) |=> mem_req_valid); // R9

    AST_NO_READY_DURING_REFILL: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !cpu_req_ready); // R9

    AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_write)
            && $stable(mem_req_addr) && $stable(mem_req_wdata)); // R10

    AST_WRITEBACK_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write && mem_req_ready) |=> mem_req_valid && !mem_req_write
            && (mem_req_addr[LINE_OFF_W +: INDEX_W] == $past(mem_req_addr[LINE_OFF_W +: INDEX_W]))); // R8

    AST_ALIGNED_STORE: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_req_write) |-> cpu_req_addr[BOFF_W-1:0] == '0); // R5
endmodule

// File: tb/dm_wb_cache_test.sv
`timescale 1ns/1ps
module dm_wb_cache_test;
    localparam int IW = 2;
    localparam int NF = 1 << IW;
    localparam int TW = 32 - IW - 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         cpu_req_valid, cpu_req_write;
    logic [31:0]  cpu_req_addr, cpu_req_wdata;
    logic [3:0]   cpu_req_be;
    logic         cpu_req_ready;
    logic [31:0]  cpu_rdata;
    logic         mem_req_valid, mem_req_write;
    logic [31:0]  mem_req_addr;
    logic [127:0] mem_req_wdata;
    logic         mem_req_ready, mem_resp_valid;
    logic [127:0] mem_resp_rdata;

    always #2 clk = ~clk;

    dm_wb_cache #(.INDEX_W(IW)) uut (.*);

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    logic [127:0] truth [logic [31:0]];
    logic [127:0] store [logic [31:0]];
    bit           r_valid [NF];
    bit           r_dirty [NF];
    logic [TW-1:0] r_tag  [NF];

    function automatic logic [127:0] seed_line(logic [31:0] ba);
        return {ba ^ 32'hDEAD_0003, ba * 3 + 32'd1, ~ba, ba ^ 32'h5A5A_5A5A};
    endfunction

    function automatic logic [127:0] get_truth(logic [31:0] ba);
        return truth.exists(ba) ? truth[ba] : seed_line(ba);
    endfunction

    function automatic logic [127:0] get_store(logic [31:0] ba);
        return store.exists(ba) ? store[ba] : seed_line(ba);
    endfunction

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(bit wr, logic [31:0] a, logic [31:0] wd, logic [3:0] be);
        logic [IW-1:0] idx = a[IW+3:4];
        logic [TW-1:0] tg  = a[31:IW+4];
        int            ws  = int'(a[3:2]);
        logic [31:0]   ba  = {a[31:4], 4'b0};
        bit hit_e = r_valid[idx] && (r_tag[idx] == tg);
        logic [127:0] ln;
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a;
        cpu_req_wdata = wd; cpu_req_be = be;
        #1;
        check(cpu_req_ready == hit_e, "R4 hit decision", 128'(cpu_req_ready), 128'(hit_e));
        if (!hit_e) begin
            bit wb_e = r_valid[idx] && r_dirty[idx];
            logic [31:0] vba = {r_tag[idx], idx, 4'b0};
            @(posedge clk); @(negedge clk);
            if (wb_e) begin
                check(mem_req_valid && mem_req_write && mem_req_addr == vba,
                      "R8 writeback address", 128'(mem_req_addr), 128'(vba));
                check(mem_req_wdata == get_truth(vba), "R8 writeback line",
                      mem_req_wdata, get_truth(vba));
                @(posedge clk); @(negedge clk);
                check(mem_req_valid && mem_req_write && mem_req_addr == vba
                      && mem_req_wdata == get_truth(vba), "R10 held writeback",
                      mem_req_wdata, get_truth(vba));
                store[vba] = mem_req_wdata;
                mem_req_ready = 1;
                @(posedge clk); @(negedge clk);
                mem_req_ready = 0;
            end
            check(mem_req_valid && !mem_req_write && mem_req_addr == ba,
                  wb_e ? "R8 fill after writeback" : "R7 single fill read",
                  {mem_req_write, mem_req_addr}, {1'b0, ba});
            check(!cpu_req_ready, "R9 stalled", 128'(cpu_req_ready), 128'(0));
            @(posedge clk); @(negedge clk);
            check(mem_req_valid && mem_req_addr == ba && !mem_req_write, "R10 held fill",
                  128'(mem_req_addr), 128'(ba));
            mem_req_ready = 1;
            @(posedge clk); @(negedge clk);
            mem_req_ready = 0;
            check(!mem_req_valid && !cpu_req_ready, "R9 waiting for data",
                  {mem_req_valid, cpu_req_ready}, 128'(0));
            @(posedge clk); @(negedge clk);
            mem_resp_valid = 1; mem_resp_rdata = get_store(ba);
            @(posedge clk); @(negedge clk);
            mem_resp_valid = 0;
            #1;
            check(cpu_req_ready, "R9 hit after fill", 128'(cpu_req_ready), 128'(1));
            r_valid[idx] = 1; r_tag[idx] = tg; r_dirty[idx] = 0;
        end
        ln = get_truth(ba);
        if (wr) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) ln[ws*32 + b*8 +: 8] = wd[b*8 +: 8];
            truth[ba] = ln;
            r_dirty[idx] = 1;
            check(!mem_req_valid, "R5 no memory traffic on write hit",
                  128'(mem_req_valid), 128'(0));
        end else begin
            check(cpu_rdata == ln[ws*32 +: 32], hit_e ? "R3 read hit word" : "R6 read after fill",
                  128'(cpu_rdata), 128'(ln[ws*32 +: 32]));
        end
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 0;
    endtask

    function automatic logic [31:0] mk(int t, int i, int w, int boff);
        return {TW'(32'h00A1_0000 + t * 32'h0001_0101), IW'(i), 2'(w), 2'(boff)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nvec++; nbad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        rst = 1; cpu_req_valid = 0; cpu_req_write = 0; cpu_req_addr = '0;
        cpu_req_wdata = '0; cpu_req_be = '0; mem_req_ready = 0;
        mem_resp_valid = 0; mem_resp_rdata = '0;
        for (int i = 0; i < NF; i++) begin r_valid[i] = 0; r_dirty[i] = 0; r_tag[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        #1;
        check(!mem_req_valid && !cpu_req_ready, "R2 reset state",
              {mem_req_valid, cpu_req_ready}, 128'(0));

        // R2/R3/R5: three tags sweep every index; stores leave lines dirty, so
        // each later tag on the same index forces an R8 eviction.
        for (int t = 0; t < 3; t++)
            for (int i = 0; i < NF; i++) begin
                for (int w = 0; w < 4; w++) access(0, mk(t, i, (w + t + i) % 4, 0), '0, '0);
                access(1, mk(t, i, (t + i) % 4, 0), 32'hC0DE_0000 + t * 16 + i, 4'((t * 4 + i) % 16));
                access(0, mk(t, i, (t + i) % 4, 3), '0, '0);        // R1 byte offset ignored
            end

        // R5: every byte-enable pattern on one word
        for (int be = 0; be < 16; be++) begin
            access(1, mk(1, 2, 1, 0), 32'h1111_1111 * be, 4'(be));
            access(0, mk(1, 2, 1, 0), '0, '0);
        end

        // R8 round trip: reload every line of every tag after evictions
        for (int t = 0; t < 3; t++)
            for (int i = 0; i < NF; i++)
                for (int w = 0; w < 4; w++) access(0, mk(t, i, w, 0), '0, '0);

        // R6: write misses on fresh tags, then read back
        for (int i = 0; i < NF; i++) begin
            access(1, mk(7, i, 3 - (i % 4), 0), 32'hFACE_B00C ^ i, 4'b0101);
            access(0, mk(7, i, 3 - (i % 4), 0), '0, '0);
            access(0, mk(8, i, 0, 0), '0, '0);                    // R4 same index new tag
            access(0, mk(7, i, 3 - (i % 4), 0), '0, '0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule